// File: doc/BRIEF.md
# OLED Panel Command Sequencer

This block brings up a monochrome OLED panel controller and then serves short command requests to it, all over a write-only serial link. The link has a chip select, a clock, a data line and a data/command select line. Every byte the block emits is a command byte, so the select line is held low for each one. Each byte, including a parameter byte that follows an opcode, goes out as its own one-byte transfer. Between bytes, chip select returns high.

An initialisation request starts the bring-up. The block first drives the panel reset low for a programmable time and then waits a programmable settle time. It then plays out a fixed command stream of 25 bytes. Three bytes of that stream depend on whether the panel has 64 rows or 32 rows, and the block samples the height input when it accepts the initialisation request.

After bring-up, a host can issue requests through a valid/ready port:
- blank the display,
- unblank the display,
- set the contrast,
- reset the address window.

A request is accepted only on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while a burst is in flight and also on a cycle where `init_req` is high. Requests are not queued: a `req_valid` presented while `req_ready` is low is dropped, and the host has to present it again once the block is ready. `busy` and a one-cycle `done` pulse report the progress of each burst.

Top module: `oled_cmd_seq`

## Requirements
- R1: After reset the block is idle. `busy`=0, `done`=0, `req_ready`=1, `panel_rst_n`=1, `spi_cs_n`=1 and `spi_sclk`=0.
- R2: An accepted `init_req` drives `panel_rst_n` low for exactly RST_CYCLES clock cycles. After `panel_rst_n` returns high, `spi_cs_n` stays high for at least SETTLE_CYCLES cycles before the first byte starts.
- R3: With `tall_panel`=1 (64 rows), bring-up sends this stream in order: AE D5 80 A8 3F D3 00 40 8D 14 20 01 A1 C8 DA 12 D9 F1 DB 40 A4 A6 AF 81 CF.
- R4: With `tall_panel`=0 (32 rows), bring-up sends the same stream except for three positions: the byte after A8 is 1F, the byte after DA is 02, and the final byte is 8F. The height is taken at the cycle the init request is accepted.
- R5: Each byte is a separate transfer in SPI mode 0, sent MSB first. During a transfer `spi_cs_n` is low for exactly 8 rising edges of `spi_sclk`. `spi_sclk` idles low. `spi_mosi` does not change while `spi_sclk` is high. `spi_cs_n` stays high for at least CS_GAP cycles between bytes.
- R6: `spi_dc` is low whenever `spi_cs_n` is low.
- R7: `req_op`=0 sends the single byte AE (blank), and `req_op`=1 sends the single byte AF (unblank).
- R8: `req_op`=2 sends 81 followed by `req_arg`, so that every 8-bit value reaches the panel unchanged.
- R9: `req_op`=3 sends 00, 10, 40 in that order (address window reset).
- R10: `req_ready` is low while `busy` is high. A request or `init_req` presented while busy has no effect, and no extra bytes appear on the link.
- R11: `busy` rises the cycle after a request is accepted. It falls only after chip select of the last byte has returned high. `done` pulses for exactly one cycle, on the cycle `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Start panel reset and bring-up (takes priority over `req_valid`) |
| tall_panel | input | 1 | 1 = 64-row panel, 0 = 32-row panel |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 blank, 1 unblank, 2 contrast, 3 window reset |
| req_arg | input | 8 | Contrast value for op 2 |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |
| panel_rst_n | output | 1 | Panel reset, active low |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_dc | output | 1 | Data/command select, low for commands |

## Verification
The bench builds the block with SCLK_HALF=1, CS_GAP=1, RST_CYCLES=5 and SETTLE_CYCLES=3. With these values a byte takes only about 20 cycles. That makes it cheap to run both panel heights through bring-up and to sweep all 256 contrast values end to end. The short reset and settle windows are small enough that their exact lengths can be counted at the pins. The bench decodes the serial link on its own and compares each byte against streams built from the requirements. It also presents requests mid-burst to show that they are dropped.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;
  localparam int IDX_W    = 5;
  localparam int INIT_LEN = 25;

  typedef enum logic [1:0] {
    OP_BLANK    = 2'd0,
    OP_UNBLANK  = 2'd1,
    OP_CONTRAST = 2'd2,
    OP_WINDOW   = 2'd3
  } op_e;

  // location of each request burst in the command table
  function automatic logic [IDX_W-1:0] op_first(op_e op);
    case (op)
      OP_BLANK:    op_first = 5'd25;
      OP_UNBLANK:  op_first = 5'd26;
      OP_CONTRAST: op_first = 5'd27;
      default:     op_first = 5'd29;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] op_last(op_e op);
    case (op)
      OP_BLANK:    op_last = 5'd25;
      OP_UNBLANK:  op_last = 5'd26;
      OP_CONTRAST: op_last = 5'd28;
      default:     op_last = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/oled_cmd_rom.sv
module oled_cmd_rom
  import oled_seq_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             tall,
  input  logic [7:0]       arg,
  output logic [7:0]       cmd
);
  always_comb begin
    case (idx)
      5'd0:  cmd = 8'hAE;
      5'd1:  cmd = 8'hD5;
      5'd2:  cmd = 8'h80;
      5'd3:  cmd = 8'hA8;
      5'd4:  cmd = tall ? 8'h3F : 8'h1F;
      5'd5:  cmd = 8'hD3;
      5'd6:  cmd = 8'h00;
      5'd7:  cmd = 8'h40;
      5'd8:  cmd = 8'h8D;
      5'd9:  cmd = 8'h14;
      5'd10: cmd = 8'h20;
      5'd11: cmd = 8'h01;
      5'd12: cmd = 8'hA1;
      5'd13: cmd = 8'hC8;
      5'd14: cmd = 8'hDA;
      5'd15: cmd = tall ? 8'h12 : 8'h02;
      5'd16: cmd = 8'hD9;
      5'd17: cmd = 8'hF1;
      5'd18: cmd = 8'hDB;
      5'd19: cmd = 8'h40;
      5'd20: cmd = 8'hA4;
      5'd21: cmd = 8'hA6;
      5'd22: cmd = 8'hAF;
      5'd23: cmd = 8'h81;
      5'd24: cmd = tall ? 8'hCF : 8'h8F;
      5'd25: cmd = 8'hAE;
      5'd26: cmd = 8'hAF;
      5'd27: cmd = 8'h81;
      5'd28: cmd = arg;
      5'd29: cmd = 8'h00;
      5'd30: cmd = 8'h10;
      default: cmd = 8'h40;
    endcase
  end
endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx #(
  parameter int SCLK_HALF = 4,
  parameter int CS_GAP    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       tx_ready,
  output logic       tx_done,
  output logic       cs_n,
  output logic       sclk,
  output logic       mosi
);
  localparam int MAXC = (SCLK_HALF > CS_GAP) ? SCLK_HALF : CS_GAP;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} st_e;

  st_e         st_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]  bit_q;
  logic [7:0]  sh_q;
  logic        cs_n_q, sclk_q;

  assign tx_ready = (st_q == S_IDLE);
  assign tx_done  = (st_q == S_GAP) && (cnt_q == CW'(CS_GAP - 1));
  assign cs_n     = cs_n_q;
  assign sclk     = sclk_q;
  assign mosi     = sh_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          sh_q   <= data;
          cs_n_q <= 1'b0;
          bit_q  <= '0;
          cnt_q  <= '0;
          st_q   <= S_LOW;
        end
        S_LOW: begin
          if (cnt_q == CW'(SCLK_HALF - 1)) begin
            sclk_q <= 1'b1;
            cnt_q  <= '0;
            st_q   <= S_HIGH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        S_HIGH: begin
          if (cnt_q == CW'(SCLK_HALF - 1)) begin
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            if (bit_q == 3'd7) begin
              cs_n_q <= 1'b1;
              st_q   <= S_GAP;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              st_q  <= S_LOW;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == CW'(CS_GAP - 1)) begin
            cnt_q <= '0;
            st_q  <= S_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(sh_q[7]));
  // R5
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> tx_ready);
endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
  import oled_seq_pkg::*;
#(
  parameter int RST_CYCLES    = 1000,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_req,
  input  logic             tall_panel,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [7:0]       req_arg,
  output logic             req_ready,
  output logic             busy,
  output logic             done,
  output logic             panel_rst_n,
  output logic [IDX_W-1:0] idx,
  output logic             tall,
  output logic [7:0]       arg,
  output logic             tx_start,
  input  logic             tx_ready,
  input  logic             tx_done
);
  localparam int MAXC = (RST_CYCLES > SETTLE_CYCLES) ? RST_CYCLES : SETTLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {C_IDLE, C_RST, C_SETTLE, C_SEND, C_WAIT} cst_e;

  cst_e             st_q;
  logic [CW-1:0]    cnt_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             tall_q, done_q;
  logic [7:0]       arg_q;
  op_e              op;

  assign op          = op_e'(req_op);
  assign req_ready   = (st_q == C_IDLE) && !init_req;
  assign busy        = (st_q != C_IDLE);
  assign done        = done_q;
  assign panel_rst_n = (st_q != C_RST);
  assign idx         = idx_q;
  assign tall        = tall_q;
  assign arg         = arg_q;
  assign tx_start    = (st_q == C_SEND) && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= C_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      tall_q <= 1'b1;
      arg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        C_IDLE: begin
          if (init_req) begin
            tall_q <= tall_panel;
            idx_q  <= '0;
            last_q <= IDX_W'(INIT_LEN - 1);
            cnt_q  <= '0;
            st_q   <= C_RST;
          end else if (req_valid) begin
            arg_q  <= req_arg;
            idx_q  <= op_first(op);
            last_q <= op_last(op);
            st_q   <= C_SEND;
          end
        end
        C_RST: begin
          if (cnt_q == CW'(RST_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= C_SETTLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        C_SETTLE: begin
          if (cnt_q == CW'(SETTLE_CYCLES - 1)) begin
            cnt_q <= '0;
            st_q  <= C_SEND;
          end else cnt_q <= cnt_q + 1'b1;
        end
        C_SEND: if (tx_ready) st_q <= C_WAIT;
        default: begin
          if (tx_done) begin
            if (idx_q == last_q) begin
              st_q   <= C_IDLE;
              done_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= C_SEND;
            end
          end
        end
      endcase
    end
  end

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R11
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(init_req || req_valid));
  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R2
  no_send_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !panel_rst_n |-> !tx_start);
endmodule

// File: rtl/oled_cmd_seq.sv
module oled_cmd_seq
  import oled_seq_pkg::*;
#(
  parameter int SCLK_HALF     = 4,
  parameter int CS_GAP        = 2,
  parameter int RST_CYCLES    = 1000,
  parameter int SETTLE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       tall_panel,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_arg,
  output logic       busy,
  output logic       done,
  output logic       panel_rst_n,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  output logic       spi_dc
);
  logic [IDX_W-1:0] idx;
  logic             tall, tx_start, tx_ready, tx_done;
  logic [7:0]       arg, cmd;

  oled_seq_ctrl #(.RST_CYCLES(RST_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk, .rst_n, .init_req, .tall_panel, .req_valid, .req_op, .req_arg,
    .req_ready, .busy, .done, .panel_rst_n, .idx, .tall, .arg,
    .tx_start, .tx_ready, .tx_done
  );

  oled_cmd_rom u_rom (.idx, .tall, .arg, .cmd);

  oled_spi_tx #(.SCLK_HALF(SCLK_HALF), .CS_GAP(CS_GAP)) u_tx (
    .clk, .rst_n, .start(tx_start), .data(cmd), .tx_ready, .tx_done,
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi)
  );

  // commands only: select line stays low throughout
  assign spi_dc = 1'b0;

  // R6
  dc_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !spi_dc);
  // R11
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !busy));
endmodule

// File: tb/sim_oled_cmd_seq.sv
module sim_oled_cmd_seq;
  localparam int HALF = 1, GAP = 1, RSTC = 5, SETC = 3;

  logic clk = 0, rst_n = 0;
  logic init_req = 0, tall_panel = 1, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [7:0] req_arg = 0;
  logic req_ready, busy, done, panel_rst_n, spi_cs_n, spi_sclk, spi_mosi, spi_dc;

  always #2 clk = ~clk;

  oled_cmd_seq #(.SCLK_HALF(HALF), .CS_GAP(GAP), .RST_CYCLES(RSTC),
                 .SETTLE_CYCLES(SETC)) u0 (.*);

  int n_chk = 0, n_fail = 0;
  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial monitor
  logic [7:0] rx [0:63];
  int nrx = 0, bits = 0, mon_err = 0, gap_err = 0, dc_err = 0, hi_cnt = 0;
  int rst_lo = 0, settle_hi = 0, done_cnt = 0;
  bit prev_sclk = 0, prev_cs = 1, prev_mosi = 0, prev_prst = 1, in_settle = 0;
  logic [7:0] shv = 0;
  always @(negedge clk) if (rst_n) begin
    if (!spi_cs_n && spi_dc) dc_err++;
    if (spi_cs_n && spi_sclk) mon_err++;
    if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) mon_err++;
    if (!spi_cs_n && spi_sclk && !prev_sclk) begin shv = {shv[6:0], spi_mosi}; bits++; end
    if (!spi_cs_n && prev_cs) begin
      if (nrx > 0 && hi_cnt < GAP) gap_err++;
      if (in_settle) begin in_settle = 0; end
      bits = 0;
    end
    if (spi_cs_n && !prev_cs) begin
      if (bits != 8) mon_err++;
      if (nrx < 64) rx[nrx] = shv;
      nrx++; hi_cnt = 0;
    end
    if (spi_cs_n) hi_cnt++;
    if (!panel_rst_n) rst_lo++;
    if (panel_rst_n && !prev_prst) begin in_settle = 1; settle_hi = 0; end
    if (in_settle && spi_cs_n) settle_hi++;
    if (done) done_cnt++;
    prev_sclk = spi_sclk; prev_cs = spi_cs_n; prev_mosi = spi_mosi; prev_prst = panel_rst_n;
  end

  function automatic logic [7:0] exp_init(int i, bit tall);
    case (i)
      0: return 8'hAE;  1: return 8'hD5;  2: return 8'h80;  3: return 8'hA8;
      4: return tall ? 8'h3F : 8'h1F;      5: return 8'hD3;  6: return 8'h00;
      7: return 8'h40;  8: return 8'h8D;  9: return 8'h14; 10: return 8'h20;
      11: return 8'h01; 12: return 8'hA1; 13: return 8'hC8; 14: return 8'hDA;
      15: return tall ? 8'h12 : 8'h02;     16: return 8'hD9; 17: return 8'hF1;
      18: return 8'hDB; 19: return 8'h40; 20: return 8'hA4; 21: return 8'hA6;
      22: return 8'hAF; 23: return 8'h81;
      default: return tall ? 8'hCF : 8'h8F;
    endcase
  endfunction

  task automatic clear_mon();
    nrx = 0; done_cnt = 0; rst_lo = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_init(bit tall);
    clear_mon();
    @(negedge clk); init_req = 1; tall_panel = tall;
    @(negedge clk); init_req = 0; tall_panel = ~tall;  // latched value must hold
    check(busy == 1, "R11 busy after init accept", busy, 1);
    wait_idle();
  endtask

  task automatic do_req(int op, int arg);
    clear_mon();
    @(negedge clk);
    check(req_ready == 1, "R10 ready when idle", req_ready, 1);
    req_valid = 1; req_op = 2'(op); req_arg = 8'(arg);
    @(negedge clk); req_valid = 0;
    wait_idle();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(req_ready == 1, "R1 ready", req_ready, 1);
    check(panel_rst_n == 1 && spi_cs_n == 1 && spi_sclk == 0, "R1 pins",
          {panel_rst_n, spi_cs_n, spi_sclk}, 3'b110);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int t = 1; t >= 0; t--) begin
      do_init(t[0]);
      check(rst_lo == RSTC, "R2 reset width", rst_lo, RSTC);
      check(settle_hi >= SETC, "R2 settle", settle_hi, SETC);
      check(nrx == 25, t ? "R3 init length" : "R4 init length", nrx, 25);
      bad = 0;
      for (int i = 0; i < 25; i++) if (rx[i] != exp_init(i, t[0])) begin
        bad++;
        $display("FAIL %s byte %0d actual=%0h expected=%0h", t ? "R3" : "R4",
                 i, rx[i], exp_init(i, t[0]));
      end
      check(bad == 0, t ? "R3 init bytes" : "R4 init bytes", bad, 0);
      check(done_cnt == 1, "R11 single done", done_cnt, 1);
    end

    do_req(0, 0);
    check(nrx == 1 && rx[0] == 8'hAE, "R7 blank", rx[0], 8'hAE);
    do_req(1, 0);
    check(nrx == 1 && rx[0] == 8'hAF, "R7 unblank", rx[0], 8'hAF);
    do_req(3, 0);
    check(nrx == 3 && rx[0] == 8'h00 && rx[1] == 8'h10 && rx[2] == 8'h40,
          "R9 window", {rx[0], rx[1], rx[2]}, 24'h001040);

    // R8 sweep all contrast values
    bad = 0;
    for (int v = 0; v < 256; v++) begin
      do_req(2, v);
      if (nrx != 2 || rx[0] != 8'h81 || rx[1] != 8'(v) || done_cnt != 1) begin
        bad++;
        $display("FAIL R8 contrast actual=%0h %0h expected=81 %0h", rx[0], rx[1], v);
      end
    end
    check(bad == 0, "R8 contrast sweep", bad, 0);

    // R10 requests while busy are dropped
    clear_mon();
    @(negedge clk); req_valid = 1; req_op = 2'd3;
    @(negedge clk); req_op = 2'd0; req_arg = 8'h55;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (req_ready) bad++;
      init_req = (k == 5);
      @(negedge clk);
    end
    init_req = 0; req_valid = 0;
    check(bad == 0, "R10 ready low while busy", bad, 0);
    wait_idle();
    repeat (60) @(negedge clk);
    check(nrx == 3, "R10 no extra bytes", nrx, 3);
    check(rst_lo == 0, "R10 init ignored while busy", rst_lo, 0);
    check(rx[2] == 8'h40, "R10 burst intact", rx[2], 8'h40);

    check(mon_err == 0, "R5 framing/mode0", mon_err, 0);
    check(gap_err == 0, "R5 cs gap", gap_err, 0);
    check(dc_err == 0, "R6 dc low", dc_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule